// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

This block moves data words from one clock domain to another through a small dual-port memory. The producer writes on its own clock and sees registered full, almost-full and write-error indications. The consumer reads on a second, unrelated clock and sees registered empty, almost-empty and read-error indications. Each side's pointer crosses to the other side in Gray code through a two-stage synchronizer. Each side compares its own pointer against that delayed copy, so both sets of flags are conservative.

A parameter selects one of two read styles. In standard style a word is delivered on the read clock edge that accepts a read request. In fall-through style the oldest stored word is already on the output, with empty low, before any request. A read request then retires that word and brings up the next one. A write attempted while full and a read attempted while empty change no state, and each raises its error flag for one cycle of its own clock.

Top module: `dcf_fifo`

## Requirements
- R1: While `rst` is high at an edge of a clock, that clock's side is cleared. After reset, `rd_empty` and `rd_aempty` are 1, and `wr_full`, `wr_afull`, `wr_err` and `rd_err` are 0.
- R2: Words leave the read port in the order they were accepted at the write port, with none lost and none repeated.
- R3: `wr_full` goes high on the write clock edge whose accepted write makes the level 2^AW. The level is counted against the read pointer as seen through the synchronizer. A write attempted while `wr_full` is high stores nothing and moves no pointer.
- R4: Every write clock cycle with `wr_en` high is one attempt. `wr_err` is high in exactly those cycles that follow an attempt made while `wr_full` was high, so a held `wr_en` on a full FIFO gives back-to-back pulses.
- R5: `wr_afull` is registered at each write clock edge. It is high when the level after that edge's write is at least 2^AW - AF_OFF, and low below that level.
- R6: The write-side flags follow R3 to R5 with the same timing in both read styles.
- R7: Space freed by a read reaches the write side only through two write clock stages. Writes attempted on the first write clock edges after such a read from a full FIFO are still rejected.
- R8: In standard style (MODE = 0), `rd_data` changes only on a read clock edge where `rd_en` is high and `rd_empty` is low. At that edge it loads the oldest word. `rd_empty` is high when the synchronized write pointer equals the read pointer.
- R9: In fall-through style (MODE = 1), the oldest word appears on `rd_data` with `rd_empty` low without any request. A read clock edge with `rd_en` high retires it, and the next word is loaded if one is visible.
- R10: A read attempted while `rd_empty` is high changes nothing. `rd_err` is high in exactly the read clock cycles that follow such an attempt.
- R11: `rd_aempty` is high when the number of words left after the current read clock edge is at most AE_OFF. In fall-through style that count includes the presented word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Active-high reset, sampled by both clocks |
| wr_en | input | 1 | Write attempt this write cycle |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | No free location as seen by the write side |
| wr_afull | output | 1 | Level at or above the almost-full mark |
| wr_err | output | 1 | Previous write attempt was rejected |
| rd_en | input | 1 | Read request this read cycle |
| rd_data | output | DW | Delivered word |
| rd_empty | output | 1 | No word available to the reader |
| rd_aempty | output | 1 | Level at or below the almost-empty mark |
| rd_err | output | 1 | Previous read request was rejected |

## Verification
The behaviour most likely to go wrong is a read that frees a slot landing close to a write attempt on a full FIFO. The rejection and the error pulse then depend on how many synchronizer and flag stages separate the two events. The bench fills the FIFO, issues one read and holds a write request right after it. It then compares full, error and acceptance on every write edge with a behavioural model that delays the read count through two write clock stages. Long random phases with both enables active and clock edges that never coincide also put reads and writes close together in time, and the model judges them in the same way for both read styles at once.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  typedef enum logic {
    RD_STANDARD = 1'b0,
    RD_FWFT     = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dcf_ptr_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a Gray pointer, with binary conversion at the output.
module dcf_ptr_sync #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] meta_q;
  logic [PW-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      bin_out[i] = ^(sync_q >> i);
    end
  end
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
// Simple dual-port storage: one write port, one registered read port.
module dcf_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
// Write pointer and write-side flags.
module dcf_wr_ctl #(
  parameter int AW     = 4,
  parameter int AF_OFF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW:0]   rsync_bin,
  output logic [AW:0]   wptr_gray,
  output logic [AW-1:0] waddr,
  output logic          mem_we,
  output logic          full,
  output logic          afull,
  output logic          err
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] LVL_FULL = PW'(DEPTH);
  localparam logic [AW:0] LVL_AF   = PW'(DEPTH - AF_OFF);

  logic [AW:0] wbin;
  logic [AW:0] wbin_nxt;
  logic [AW:0] fill_nxt;

  assign mem_we = wr_en & ~full;
  assign waddr  = wbin[AW-1:0];

  always_comb begin
    wbin_nxt = wbin + PW'(mem_we);
    fill_nxt = wbin_nxt - rsync_bin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin      <= '0;
      wptr_gray <= '0;
      full      <= 1'b0;
      afull     <= 1'b0;
      err       <= 1'b0;
    end else begin
      wbin      <= wbin_nxt;
      wptr_gray <= wbin_nxt ^ (wbin_nxt >> 1);
      full      <= (fill_nxt == LVL_FULL);
      afull     <= (fill_nxt >= LVL_AF);
      err       <= wr_en & full;
    end
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
// Read pointer, read-side flags and the read-style variants.
module dcf_rd_ctl #(
  parameter int AW     = 4,
  parameter int AE_OFF = 2,
  parameter dcf_pkg::rd_mode_e MODE = dcf_pkg::RD_STANDARD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW:0]   wsync_bin,
  output logic [AW:0]   rptr_gray,
  output logic [AW-1:0] raddr,
  output logic          mem_re,
  output logic          empty,
  output logic          aempty,
  output logic          err
);
  localparam int PW = AW + 1;
  localparam logic [AW:0] LVL_AE = PW'(AE_OFF);

  logic [AW:0] rbin;
  logic [AW:0] rbin_nxt;
  logic [AW:0] cfill_nxt;
  logic [AW:0] level_nxt;
  logic        cempty;
  logic        empty_now;

  assign raddr = rbin[AW-1:0];
  assign empty = empty_now;

  always_comb begin
    rbin_nxt  = rbin + PW'(mem_re);
    cfill_nxt = wsync_bin - rbin_nxt;
  end

  generate
    if (MODE == dcf_pkg::RD_FWFT) begin : g_fwft
      logic held;
      logic held_nxt;
      always_comb begin
        mem_re    = ~cempty & (~held | rd_en);
        held_nxt  = mem_re | (held & ~rd_en);
        empty_now = ~held;
        level_nxt = cfill_nxt + PW'(held_nxt);
      end
      always_ff @(posedge clk) begin
        if (rst) held <= 1'b0;
        else     held <= held_nxt;
      end
    end else begin : g_std
      always_comb begin
        mem_re    = rd_en & ~cempty;
        empty_now = cempty;
        level_nxt = cfill_nxt;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin      <= '0;
      rptr_gray <= '0;
      cempty    <= 1'b1;
      aempty    <= 1'b1;
      err       <= 1'b0;
    end else begin
      rbin      <= rbin_nxt;
      rptr_gray <= rbin_nxt ^ (rbin_nxt >> 1);
      cempty    <= (cfill_nxt == '0);
      aempty    <= (level_nxt <= LVL_AE);
      err       <= rd_en & empty_now;
    end
  end
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo #(
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter int AF_OFF = 2,
  parameter int AE_OFF = 2,
  parameter dcf_pkg::rd_mode_e MODE = dcf_pkg::RD_STANDARD
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  output logic          wr_afull,
  output logic          wr_err,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic          rd_aempty,
  output logic          rd_err
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr_gray;
  logic [PW-1:0] rptr_gray;
  logic [PW-1:0] rsync_bin;
  logic [PW-1:0] wsync_bin;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic          mem_we;
  logic          mem_re;

  dcf_ptr_sync #(.PW(PW)) u_rsync (
    .clk(wclk), .rst(rst), .gray_in(rptr_gray), .bin_out(rsync_bin)
  );

  dcf_ptr_sync #(.PW(PW)) u_wsync (
    .clk(rclk), .rst(rst), .gray_in(wptr_gray), .bin_out(wsync_bin)
  );

  dcf_wr_ctl #(.AW(AW), .AF_OFF(AF_OFF)) u_wr (
    .clk(wclk), .rst(rst), .wr_en(wr_en), .rsync_bin(rsync_bin),
    .wptr_gray(wptr_gray), .waddr(waddr), .mem_we(mem_we),
    .full(wr_full), .afull(wr_afull), .err(wr_err)
  );

  dcf_rd_ctl #(.AW(AW), .AE_OFF(AE_OFF), .MODE(MODE)) u_rd (
    .clk(rclk), .rst(rst), .rd_en(rd_en), .wsync_bin(wsync_bin),
    .rptr_gray(rptr_gray), .raddr(raddr), .mem_re(mem_re),
    .empty(rd_empty), .aempty(rd_aempty), .err(rd_err)
  );

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .rst(rst), .re(mem_re), .raddr(raddr), .q(rd_data)
  );
endmodule

// File: rtl/dcf_fifo_chk.sv
`timescale 1ns/1ps
module dcf_fifo_chk #(
  parameter int PW = 5
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic          wr_en,
  input logic          wr_full,
  input logic          wr_afull,
  input logic          wr_err,
  input logic          rd_en,
  input logic          rd_empty,
  input logic          rd_aempty,
  input logic          rd_err,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray
);
  a_r1_wr_reset: assert property (@(posedge wclk)
    rst |=> (!wr_full && !wr_afull && !wr_err));
  a_r1_rd_reset: assert property (@(posedge rclk)
    rst |=> (rd_empty && rd_aempty && !rd_err));
  a_r3_no_write_when_full: assert property (@(posedge wclk) disable iff (rst)
    (wr_full && wr_en) |=> $stable(wgray));
  a_r4_err_after_reject: assert property (@(posedge wclk) disable iff (rst)
    (wr_full && wr_en) |=> wr_err);
  a_r4_no_spurious_err: assert property (@(posedge wclk) disable iff (rst)
    !(wr_full && wr_en) |=> !wr_err);
  a_r5_full_within_afull: assert property (@(posedge wclk) disable iff (rst)
    wr_full |-> wr_afull);
  a_r2_wgray_one_step: assert property (@(posedge wclk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
  a_r2_rgray_one_step: assert property (@(posedge rclk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);
  a_r10_rd_err_after_reject: assert property (@(posedge rclk) disable iff (rst)
    (rd_empty && rd_en) |=> rd_err);
  a_r10_no_spurious_rd_err: assert property (@(posedge rclk) disable iff (rst)
    !(rd_empty && rd_en) |=> !rd_err);
  a_r11_empty_within_aempty: assert property (@(posedge rclk) disable iff (rst)
    rd_empty |-> rd_aempty);
endmodule

bind dcf_fifo dcf_fifo_chk #(.PW(AW + 1)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst),
  .wr_en(wr_en), .wr_full(wr_full), .wr_afull(wr_afull), .wr_err(wr_err),
  .rd_en(rd_en), .rd_empty(rd_empty), .rd_aempty(rd_aempty), .rd_err(rd_err),
  .wgray(wptr_gray), .rgray(rptr_gray)
);

// File: tb/dcf_fifo_test.sv
`timescale 1ns/1ps
// Behavioural reference: counters, a queue and a two-stage delay of counts.
module dcf_ref_model #(
  parameter int DW = 8, parameter int AW = 4,
  parameter int AF = 2, parameter int AE = 2, parameter bit FWFT = 0
) (
  input  logic          wclk, rclk, rst, wr_en, rd_en,
  input  logic [DW-1:0] wr_data,
  output logic          e_full, e_afull, e_werr, e_empty, e_aempty, e_rerr,
  output logic [DW-1:0] e_dout
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] q[$];
  int wcnt, rcnt, s1, s2, t1, t2, fill, cf;
  bit cempty, held, core, acc, bad;

  always @(posedge wclk) begin
    if (rst) begin
      wcnt = 0; s1 = 0; s2 = 0; q.delete();
      e_full = 0; e_afull = 0; e_werr = 0;
    end else begin
      acc = wr_en && !e_full;
      bad = wr_en && e_full;
      if (acc) begin q.push_back(wr_data); wcnt++; end
      fill = wcnt - s2;
      e_full = (fill == DEPTH);
      e_afull = (fill >= DEPTH - AF);
      e_werr = bad;
      s2 = s1; s1 = rcnt;
    end
  end

  always @(posedge rclk) begin
    if (rst) begin
      rcnt = 0; t1 = 0; t2 = 0; cempty = 1; held = 0;
      e_empty = 1; e_aempty = 1; e_rerr = 0; e_dout = '0;
    end else begin
      if (FWFT) begin
        core = !cempty && (!held || rd_en);
        e_rerr = rd_en && !held;
        held = core ? 1'b1 : (rd_en ? 1'b0 : held);
      end else begin
        core = rd_en && !cempty;
        e_rerr = rd_en && cempty;
      end
      if (core) begin e_dout = q.pop_front(); rcnt++; end
      cf = t2 - rcnt;
      cempty = (cf == 0);
      e_aempty = ((cf + (FWFT ? int'(held) : 0)) <= AE);
      e_empty = FWFT ? !held : cempty;
      t2 = t1; t1 = wcnt;
    end
  end
endmodule

module dcf_fifo_test;
  localparam int DW = 8, AW = 4, AF = 2, AE = 2;

  logic wclk = 0, rclk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  int nchk = 0, nerr = 0;
  logic [DW-1:0] dcnt = 8'h10;

  always #4 wclk = ~wclk;
  initial begin #1.5; forever #5 rclk = ~rclk; end

  logic s_full, s_afull, s_werr, s_empty, s_aempty, s_rerr;
  logic f_full, f_afull, f_werr, f_empty, f_aempty, f_rerr;
  logic [DW-1:0] s_data, f_data;
  logic es_full, es_afull, es_werr, es_empty, es_aempty, es_rerr;
  logic ef_full, ef_afull, ef_werr, ef_empty, ef_aempty, ef_rerr;
  logic [DW-1:0] es_data, ef_data;

  dcf_fifo #(.DW(DW), .AW(AW), .AF_OFF(AF), .AE_OFF(AE), .MODE(dcf_pkg::RD_STANDARD)) uut (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(s_full), .wr_afull(s_afull), .wr_err(s_werr), .rd_en(rd_en),
    .rd_data(s_data), .rd_empty(s_empty), .rd_aempty(s_aempty), .rd_err(s_rerr));

  dcf_fifo #(.DW(DW), .AW(AW), .AF_OFF(AF), .AE_OFF(AE), .MODE(dcf_pkg::RD_FWFT)) uut_fw (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(f_full), .wr_afull(f_afull), .wr_err(f_werr), .rd_en(rd_en),
    .rd_data(f_data), .rd_empty(f_empty), .rd_aempty(f_aempty), .rd_err(f_rerr));

  dcf_ref_model #(.DW(DW), .AW(AW), .AF(AF), .AE(AE), .FWFT(0)) m_s (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .e_full(es_full), .e_afull(es_afull), .e_werr(es_werr), .e_empty(es_empty),
    .e_aempty(es_aempty), .e_rerr(es_rerr), .e_dout(es_data));

  dcf_ref_model #(.DW(DW), .AW(AW), .AF(AF), .AE(AE), .FWFT(1)) m_f (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .e_full(ef_full), .e_afull(ef_afull), .e_werr(ef_werr), .e_empty(ef_empty),
    .e_aempty(ef_aempty), .e_rerr(ef_rerr), .e_dout(ef_data));

  task automatic chk(input bit ok, input string rq, input string nm, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, nm, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  // Write side compared every write cycle, read side every read cycle.
  always @(posedge wclk) begin
    #2;
    if (!rst) begin
      chk(s_full == es_full,   "R3", "std wr_full",  s_full,  es_full);
      chk(s_afull == es_afull, "R5", "std wr_afull", s_afull, es_afull);
      chk(s_werr == es_werr,   "R4", "std wr_err",   s_werr,  es_werr);
      chk(f_full == ef_full,   "R6", "fwft wr_full",  f_full,  ef_full);
      chk(f_afull == ef_afull, "R6", "fwft wr_afull", f_afull, ef_afull);
      chk(f_werr == ef_werr,   "R6", "fwft wr_err",   f_werr,  ef_werr);
    end
  end

  always @(posedge rclk) begin
    #2;
    if (!rst) begin
      chk(s_data == es_data,     "R2", "std rd_data",   s_data,   es_data);
      chk(s_empty == es_empty,   "R8", "std rd_empty",  s_empty,  es_empty);
      chk(s_aempty == es_aempty, "R11", "std rd_aempty", s_aempty, es_aempty);
      chk(s_rerr == es_rerr,     "R10", "std rd_err",   s_rerr,   es_rerr);
      chk(f_data == ef_data,     "R9", "fwft rd_data",  f_data,   ef_data);
      chk(f_empty == ef_empty,   "R9", "fwft rd_empty", f_empty,  ef_empty);
      chk(f_aempty == ef_aempty, "R11", "fwft rd_aempty", f_aempty, ef_aempty);
      chk(f_rerr == ef_rerr,     "R10", "fwft rd_err",  f_rerr,   ef_rerr);
    end
  end

  task automatic wr_cycle(input bit en);
    @(negedge wclk);
    wr_en = en;
    if (en) begin wr_data = dcnt; dcnt = dcnt + 8'd1; end
  endtask

  task automatic rd_cycle(input bit en);
    @(negedge rclk);
    rd_en = en;
  endtask

  initial begin
    #1_500_000;
    nchk++; nerr++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (6) @(negedge rclk);
    rst = 0;
    @(negedge wclk);
    // R1: state straight after reset
    chk(s_empty && s_aempty && f_empty && f_aempty, "R1", "empty flags after reset", s_empty, 1);
    chk(!s_full && !s_afull && !s_werr && !s_rerr, "R1", "std flags after reset", s_full, 0);
    chk(!f_full && !f_afull && !f_werr && !f_rerr, "R1", "fwft flags after reset", f_full, 0);

    // R9 / R8: one word, no read request
    dcnt = 8'hA5;
    wr_cycle(1);
    wr_cycle(0);
    repeat (6) @(negedge rclk);
    chk(!f_empty && f_data == 8'hA5, "R9", "fwft presents first word", f_data, 8'hA5);
    chk(!s_empty && s_data == 8'h00, "R8", "std holds output without request", s_data, 0);

    // R3 / R4: fill past full with write held high
    repeat (22) wr_cycle(1);
    wr_cycle(0);
    @(negedge wclk);
    chk(s_full && f_full, "R3", "full after overfill", s_full, 1);
    chk(!s_werr, "R4", "no error once attempts stop", s_werr, 0);

    // R7: one read from a full FIFO, then an immediate write attempt
    rd_cycle(1);
    rd_cycle(0);
    wr_cycle(1);
    @(posedge wclk); #2;
    chk(s_werr == 1'b1, "R7", "write right after read still rejected", s_werr, 1);
    repeat (5) wr_cycle(1);
    wr_cycle(0);

    // R10: drain past empty with read held high
    repeat (24) rd_cycle(1);
    rd_cycle(0);
    repeat (3) @(negedge rclk);
    chk(s_empty && f_empty, "R10", "empty after overdrain", s_empty, 1);

    // Random traffic, several rate mixes on each side
    fork
      begin
        for (int seg = 0; seg < 4; seg++) begin
          for (int i = 0; i < 700; i++) wr_cycle($urandom_range(99) < (seg % 2 ? 30 : 85));
        end
        wr_cycle(0);
      end
      begin
        for (int seg = 0; seg < 4; seg++) begin
          for (int i = 0; i < 560; i++) rd_cycle($urandom_range(99) < (seg < 2 ? 40 : 75));
        end
        rd_cycle(0);
      end
    join

    repeat (10) @(negedge wclk);
    repeat (40) rd_cycle(1);
    rd_cycle(0);
    repeat (4) @(negedge rclk);
    chk(s_empty && f_empty, "R2", "all words delivered", s_empty, 1);
    finish_run();
  end
endmodule